// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Transceiver

This block is an asynchronous serial transmitter and receiver for a line shared by several nodes. A character is 8 data bits, sent least significant bit first, with an optional ninth bit and one or two stop bits. The ninth bit can be a parity bit, even or odd. In multiprocessor mode the ninth bit is instead a control bit chosen by software. Each node uses that bit to tell address characters apart from data characters, and parity is then unavailable.

The surrounding logic supplies a 16x oversampling tick. It hands over a byte and a ninth bit through a valid/ready pair and receives each character as a one-cycle strobe with the byte and the ninth bit beside it. Framing, parity and break errors are sticky flags. A one-cycle status-read pulse clears them. Baud generation and buffering live outside the block.

Top module: `mp_uart`

## Requirements
- R1: After reset the serial output is high, the transmitter is ready, the receive strobe is low and all three error flags are clear; whenever the transmitter is ready the serial output is high.
- R2: An accepted byte goes out as a low start bit, then data bits 0 through 7, then a high stop bit, each bit lasting 16 ticks.
- R3: The ninth bit follows data bit 7 and precedes the stop bits. In multiprocessor mode it is the supplied ninth bit. Otherwise, with parity on, it is the XOR of the 8 data bits for even parity and its inverse for odd parity. Multiprocessor mode overrides parity enable.
- R4: With two stop bits selected the line stays high for two bit times, and the transmitter becomes ready again only after the last stop bit ends.
- R5: A received character raises the receive strobe for exactly one clock, with the byte and the ninth bit on their outputs. The ninth output is 0 when no ninth bit is configured.
- R6: While receive enable is low no character is received and the received byte output keeps its value.
- R7: A low pulse shorter than half a bit time is rejected as a false start and produces no character.
- R8: A stop bit sampled low sets the framing flag, which stays set until a status-read pulse.
- R9: With parity on and multiprocessor mode off, a ninth bit that does not match the parity of the received byte (XOR for even, inverse for odd) sets the parity flag. The flag stays set until a status-read pulse.
- R10: A character whose data, ninth bit and stop bit are all low sets both the break flag and the framing flag. A long low line yields only one character, and reception rearms once the line returns high.
- R11: In multiprocessor mode no parity error is ever raised, and the received ninth bit appears on the ninth output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| txValid | input | 1 | Transmit request |
| txData | input | 8 | Byte to transmit |
| txNinth | input | 1 | Ninth bit to send in multiprocessor mode |
| txReady | output | 1 | Transmitter idle, request accepted |
| txLine | output | 1 | Serial output |
| rxEnable | input | 1 | Receiver enable |
| rxLine | input | 1 | Serial input |
| rxValid | output | 1 | One-cycle strobe for a received character |
| rxData | output | 8 | Received byte |
| rxNinth | output | 1 | Received ninth bit |
| parityEnable | input | 1 | Parity on (ignored in multiprocessor mode) |
| parityOdd | input | 1 | 1 selects odd parity, 0 even |
| twoStop | input | 1 | 1 selects two stop bits |
| mpMode | input | 1 | Multiprocessor nine-bit mode |
| statusRead | input | 1 | Pulse that clears the error flags |
| frameErr | output | 1 | Sticky framing error |
| parityErr | output | 1 | Sticky parity error |
| breakErr | output | 1 | Sticky break detected |

## Verification
A wrong bit counter or state in the transmitter shows up on the serial output within one bit time: a bit lands in the wrong slot, the ninth bit is missing, or the stop bit is too short. The ready output returns early or late. On the receive side, a bad sample phase or shift order gives a wrong byte or a wrong ninth bit at the very next strobe. A wrong rule for setting or clearing the flags shows in the flags right after that strobe or after the status-read pulse. A receiver that does not rearm after a break gives extra strobes, or misses the next character entirely.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;

  typedef enum logic [1:0] {
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_NINTH
  } line_sel_e;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_NINTH,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP,
    RX_WAIT
  } rx_state_e;

  typedef struct packed {
    logic      txLoad;
    logic      txShift;
    line_sel_e txSel;
    logic      rxClear;
    logic      rxShift;
    logic      rxTakeNinth;
    logic      rxFinish;
  } uart_strobe_t;

endpackage

// File: rtl/mp_uart_ctrl.sv
module mp_uart_ctrl
  import mp_uart_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         txValid,
  input  logic         parityEnable,
  input  logic         mpMode,
  input  logic         twoStop,
  input  logic         rxEnable,
  input  logic         rxBit,
  output uart_strobe_t strb,
  output logic         txReady
);

  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  // transmit sequencing
  tx_state_e        txState, txStateN;
  logic [CNT_W-1:0] txCnt, txCntN;
  logic [IDX_W-1:0] txIdx, txIdxN;
  logic             txSecondStop, txSecondStopN;
  logic             txHasNinth, txTwoStop;
  logic             txEnd;
  logic             load, shift;

  always_comb begin
    txStateN      = txState;
    txCntN        = txCnt;
    txIdxN        = txIdx;
    txSecondStopN = txSecondStop;
    load          = 1'b0;
    shift         = 1'b0;
    txEnd         = tick && (txCnt == LAST_CNT);
    if (txState != TX_IDLE && tick) begin
      txCntN = txEnd ? '0 : txCnt + 1'b1;
    end
    case (txState)
      TX_IDLE: begin
        if (txValid) begin
          load     = 1'b1;
          txStateN = TX_START;
          txCntN   = '0;
        end
      end
      TX_START: begin
        if (txEnd) begin
          txStateN = TX_DATA;
          txIdxN   = '0;
        end
      end
      TX_DATA: begin
        if (txEnd) begin
          shift = 1'b1;
          if (txIdx == LAST_IDX) begin
            txStateN      = txHasNinth ? TX_NINTH : TX_STOP;
            txSecondStopN = 1'b0;
          end else begin
            txIdxN = txIdx + 1'b1;
          end
        end
      end
      TX_NINTH: begin
        if (txEnd) begin
          txStateN      = TX_STOP;
          txSecondStopN = 1'b0;
        end
      end
      TX_STOP: begin
        if (txEnd) begin
          if (txTwoStop && !txSecondStop) begin
            txSecondStopN = 1'b1;
          end else begin
            txStateN = TX_IDLE;
          end
        end
      end
      default: txStateN = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState      <= TX_IDLE;
      txCnt        <= '0;
      txIdx        <= '0;
      txSecondStop <= 1'b0;
      txHasNinth   <= 1'b0;
      txTwoStop    <= 1'b0;
    end else begin
      txState      <= txStateN;
      txCnt        <= txCntN;
      txIdx        <= txIdxN;
      txSecondStop <= txSecondStopN;
      if (load) begin
        txHasNinth <= mpMode | parityEnable;
        txTwoStop  <= twoStop;
      end
    end
  end

  // receive sequencing
  rx_state_e        rxState, rxStateN;
  logic [CNT_W-1:0] rxCnt, rxCntN;
  logic [IDX_W-1:0] rxIdx, rxIdxN;
  logic             rxMid, rxEnd;
  logic             clearS, sampleS, ninthS, finishS;

  always_comb begin
    rxStateN = rxState;
    rxCntN   = rxCnt;
    rxIdxN   = rxIdx;
    clearS   = 1'b0;
    sampleS  = 1'b0;
    ninthS   = 1'b0;
    finishS  = 1'b0;
    rxMid    = tick && (rxCnt == MID_CNT);
    rxEnd    = tick && (rxCnt == LAST_CNT);
    if (!rxEnable) begin
      rxStateN = RX_IDLE;
      rxCntN   = '0;
    end else begin
      if (rxState != RX_IDLE && rxState != RX_WAIT && tick) begin
        rxCntN = rxEnd ? '0 : rxCnt + 1'b1;
      end
      case (rxState)
        RX_IDLE: begin
          if (tick && !rxBit) begin
            rxStateN = RX_START;
            rxCntN   = '0;
          end
        end
        RX_START: begin
          if (rxMid) begin
            if (!rxBit) begin
              rxStateN = RX_DATA;
              rxCntN   = '0;
              rxIdxN   = '0;
              clearS   = 1'b1;
            end else begin
              rxStateN = RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (rxEnd) begin
            sampleS = 1'b1;
            if (rxIdx == LAST_IDX) begin
              rxStateN = (mpMode || parityEnable) ? RX_NINTH : RX_STOP;
            end else begin
              rxIdxN = rxIdx + 1'b1;
            end
          end
        end
        RX_NINTH: begin
          if (rxEnd) begin
            ninthS   = 1'b1;
            rxStateN = RX_STOP;
          end
        end
        RX_STOP: begin
          if (rxEnd) begin
            finishS  = 1'b1;
            rxStateN = rxBit ? RX_IDLE : RX_WAIT;
          end
        end
        RX_WAIT: begin
          if (rxBit) rxStateN = RX_IDLE;
        end
        default: rxStateN = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      rxState <= rxStateN;
      rxCnt   <= rxCntN;
      rxIdx   <= rxIdxN;
    end
  end

  always_comb begin
    strb.txLoad      = load;
    strb.txShift     = shift;
    strb.rxClear     = clearS;
    strb.rxShift     = sampleS;
    strb.rxTakeNinth = ninthS;
    strb.rxFinish    = finishS;
    case (txState)
      TX_START: strb.txSel = LINE_START;
      TX_DATA:  strb.txSel = LINE_DATA;
      TX_NINTH: strb.txSel = LINE_NINTH;
      default:  strb.txSel = LINE_IDLE;
    endcase
  end

  assign txReady = (txState == TX_IDLE);

endmodule

// File: rtl/mp_uart_dp.sv
module mp_uart_dp
  import mp_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  uart_strobe_t      strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  input  logic              parityEnable,
  input  logic              parityOdd,
  input  logic              mpMode,
  input  logic              rxLine,
  input  logic              statusRead,
  output logic              txLine,
  output logic              rxBit,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              frameErr,
  output logic              parityErr,
  output logic              breakErr
);

  // input synchronizer, idles high
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxLine;
      end
    end
  endgenerate
  assign rxBit = syncQ[SYNC_STAGES-1];

  // transmit path
  logic [DATA_W-1:0] txShiftReg;
  logic              txNinthReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      txNinthReg <= 1'b0;
      txLine     <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txShiftReg <= txData;
        txNinthReg <= mpMode ? txNinth : (parityOdd ? ~^txData : ^txData);
      end else if (strb.txShift) begin
        txShiftReg <= txShiftReg >> 1;
      end
      case (strb.txSel)
        LINE_START: txLine <= 1'b0;
        LINE_DATA:  txLine <= txShiftReg[0];
        LINE_NINTH: txLine <= txNinthReg;
        default:    txLine <= 1'b1;
      endcase
    end
  end

  // receive path
  logic [DATA_W-1:0] rxShiftReg;
  logic              rxNinthReg;
  logic              hasNinth, stopLow, parityBad, allZero;

  assign hasNinth  = mpMode | parityEnable;
  assign stopLow   = ~rxBit;
  assign allZero   = (rxShiftReg == '0) && !rxNinthReg;
  assign parityBad = parityEnable && !mpMode &&
                     (rxNinthReg != (parityOdd ? ~^rxShiftReg : ^rxShiftReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxNinthReg <= 1'b0;
      rxValid    <= 1'b0;
      rxData     <= '0;
      rxNinth    <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      breakErr   <= 1'b0;
    end else begin
      if (strb.rxClear) begin
        rxShiftReg <= '0;
        rxNinthReg <= 1'b0;
      end else if (strb.rxShift) begin
        rxShiftReg <= {rxBit, rxShiftReg[DATA_W-1:1]};
      end else if (strb.rxTakeNinth) begin
        rxNinthReg <= rxBit;
      end
      rxValid <= strb.rxFinish;
      if (strb.rxFinish) begin
        rxData  <= rxShiftReg;
        rxNinth <= hasNinth & rxNinthReg;
      end
      frameErr  <= (frameErr  & ~statusRead) | (strb.rxFinish & stopLow);
      parityErr <= (parityErr & ~statusRead) | (strb.rxFinish & parityBad);
      breakErr  <= (breakErr  & ~statusRead) | (strb.rxFinish & stopLow & allZero);
    end
  end

endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxEnable,
  input  logic              rxLine,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  input  logic              parityEnable,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              mpMode,
  input  logic              statusRead,
  output logic              frameErr,
  output logic              parityErr,
  output logic              breakErr
);

  uart_strobe_t strb;
  logic         rxBit;

  mp_uart_ctrl #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick16),
    .txValid      (txValid),
    .parityEnable (parityEnable),
    .mpMode       (mpMode),
    .twoStop      (twoStop),
    .rxEnable     (rxEnable),
    .rxBit        (rxBit),
    .strb         (strb),
    .txReady      (txReady)
  );

  mp_uart_dp #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .txData       (txData),
    .txNinth      (txNinth),
    .parityEnable (parityEnable),
    .parityOdd    (parityOdd),
    .mpMode       (mpMode),
    .rxLine       (rxLine),
    .statusRead   (statusRead),
    .txLine       (txLine),
    .rxBit        (rxBit),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .rxNinth      (rxNinth),
    .frameErr     (frameErr),
    .parityErr    (parityErr),
    .breakErr     (breakErr)
  );

endmodule

// File: rtl/mp_uart_checker.sv
module mp_uart_checker (
  input logic clk,
  input logic rstN,
  input logic txReady,
  input logic txLine,
  input logic rxEnable,
  input logic rxValid,
  input logic mpMode,
  input logic statusRead,
  input logic frameErr,
  input logic parityErr,
  input logic breakErr
);

  assert_ready_line_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_no_rx_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxValid);

  assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !statusRead) |=> frameErr);

  assert_parity_with_char_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> rxValid);

  assert_break_implies_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakErr) |-> frameErr);

  assert_no_parity_in_mp_R11: assert property (@(posedge clk) disable iff (!rstN)
    mpMode |-> !$rose(parityErr));

endmodule

bind mp_uart mp_uart_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .txReady    (txReady),
  .txLine     (txLine),
  .rxEnable   (rxEnable),
  .rxValid    (rxValid),
  .mpMode     (mpMode),
  .statusRead (statusRead),
  .frameErr   (frameErr),
  .parityErr  (parityErr),
  .breakErr   (breakErr)
);

// File: tb/mp_uart_test.sv
module mp_uart_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txNinth = 1'b0;
  logic       txReady;
  logic       txLine;
  logic       rxEnable = 1'b1;
  logic       rxLine = 1'b1;
  logic       rxValid;
  logic [7:0] rxData;
  logic       rxNinth;
  logic       parityEnable = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       mpMode = 1'b0;
  logic       statusRead = 1'b0;
  logic       frameErr, parityErr, breakErr;

  int compared = 0;
  int mismatched = 0;
  int tickDiv = 0;
  int rxCount = 0;
  logic [7:0] lastData = 8'h00;
  logic       lastNinth = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tick16  <= (tickDiv == 3);
  end

  always @(negedge clk) begin
    if (rxValid) begin
      rxCount   <= rxCount + 1;
      lastData  <= rxData;
      lastNinth <= rxNinth;
    end
  end

  mp_uart uut (
    .clk(clk), .rstN(rstN), .tick16(tick16),
    .txValid(txValid), .txData(txData), .txNinth(txNinth),
    .txReady(txReady), .txLine(txLine),
    .rxEnable(rxEnable), .rxLine(rxLine),
    .rxValid(rxValid), .rxData(rxData), .rxNinth(rxNinth),
    .parityEnable(parityEnable), .parityOdd(parityOdd),
    .twoStop(twoStop), .mpMode(mpMode), .statusRead(statusRead),
    .frameErr(frameErr), .parityErr(parityErr), .breakErr(breakErr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
  endtask

  function automatic logic parityOf(input logic [7:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction

  function automatic logic [11:0] expFrame(input logic [7:0] d, input logic ninth,
                                           input logic pe, input logic odd, input logic mp);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (mp) f[9] = ninth;
    else if (pe) f[9] = parityOf(d, odd);
    return f;
  endfunction

  task automatic setCfg(input logic pe, input logic odd, input logic mp, input logic two);
    @(negedge clk);
    parityEnable = pe;
    parityOdd    = odd;
    mpMode       = mp;
    twoStop      = two;
  endtask

  task automatic sendTx(input logic [7:0] d, input logic ninth, input string req);
    int nBits;
    logic [11:0] got;
    logic [11:0] exp;
    nBits = 10 + ((parityEnable | mpMode) ? 1 : 0) + (twoStop ? 1 : 0);
    exp = expFrame(d, ninth, parityEnable, parityOdd, mpMode);
    got = '1;
    @(negedge clk);
    txData  = d;
    txNinth = ninth;
    txValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    waitTicks(8);
    #1 got[0] = txLine;
    for (int k = 1; k < nBits; k++) begin
      waitTicks(16);
      #1 got[k] = txLine;
    end
    check(req, "serial frame", {20'h0, got}, {20'h0, exp});
    check("R4", "busy during last stop", {31'h0, txReady}, 32'h0);
    waitTicks(8);
    #1 check("R4", "ready after stop", {31'h0, txReady}, 32'h1);
  endtask

  task automatic sendRx(input logic [7:0] d, input logic hasNinth,
                        input logic ninth, input logic stopBit);
    rxLine = 1'b0;
    waitTicks(16);
    #1;
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      waitTicks(16);
      #1;
    end
    if (hasNinth) begin
      rxLine = ninth;
      waitTicks(16);
      #1;
    end
    rxLine = stopBit;
    waitTicks(16);
    #1 rxLine = 1'b1;
    waitTicks(4);
    #1;
  endtask

  task automatic pulseStatusRead();
    @(negedge clk) statusRead = 1'b1;
    @(negedge clk) statusRead = 1'b0;
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int c0;
    logic [7:0] d;
    logic n, pe, od, mp, two, sent, hasN;
    void'($urandom(32'h0000_5EED));

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "txLine idle", {31'h0, txLine}, 32'h1);
    check("R1", "txReady", {31'h0, txReady}, 32'h1);
    check("R1", "rxValid", {31'h0, rxValid}, 32'h0);
    check("R1", "flags", {29'h0, frameErr, parityErr, breakErr}, 32'h0);

    // directed transmit corners
    setCfg(1'b0, 1'b0, 1'b0, 1'b0);
    sendTx(8'hA5, 1'b0, "R2");
    sendTx(8'h01, 1'b0, "R2");
    setCfg(1'b1, 1'b0, 1'b0, 1'b0);
    sendTx(8'h07, 1'b0, "R3");
    setCfg(1'b1, 1'b1, 1'b0, 1'b1);
    sendTx(8'h07, 1'b0, "R3");
    setCfg(1'b1, 1'b0, 1'b1, 1'b1);
    sendTx(8'h03, 1'b0, "R3");
    sendTx(8'h80, 1'b1, "R3");

    // random transmit and receive
    for (int it = 0; it < 20; it++) begin
      pe  = 1'($urandom);
      od  = 1'($urandom);
      mp  = 1'($urandom);
      two = 1'($urandom);
      d   = 8'($urandom);
      n   = 1'($urandom);
      if (it == 0) d = 8'hFF;
      if (it == 1) d = 8'h80;
      setCfg(pe, od, mp, two);
      sendTx(d, n, mp ? "R3" : "R2");
      hasN = mp | pe;
      sent = mp ? n : (pe ? parityOf(d, od) : 1'b0);
      c0 = rxCount;
      sendRx(d, hasN, sent, 1'b1);
      check("R5", "one character", rxCount, c0 + 1);
      check("R5", "data", {24'h0, lastData}, {24'h0, d});
      check(mp ? "R11" : "R5", "ninth", {31'h0, lastNinth}, {31'h0, hasN & sent});
      check("R9", "no error flags", {29'h0, frameErr, parityErr, breakErr}, 32'h0);
    end

    // parity mismatch, even
    setCfg(1'b1, 1'b0, 1'b0, 1'b0);
    sendRx(8'h03, 1'b1, 1'b1, 1'b1);
    check("R9", "parity flag set", {31'h0, parityErr}, 32'h1);
    check("R9", "frame flag clear", {31'h0, frameErr}, 32'h0);
    waitTicks(20);
    #1 check("R9", "parity flag sticky", {31'h0, parityErr}, 32'h1);
    pulseStatusRead();
    check("R9", "parity flag cleared", {31'h0, parityErr}, 32'h0);
    // parity mismatch, odd
    setCfg(1'b1, 1'b1, 1'b0, 1'b0);
    sendRx(8'h01, 1'b1, 1'b1, 1'b1);
    check("R9", "odd parity flag", {31'h0, parityErr}, 32'h1);
    pulseStatusRead();

    // multiprocessor mode ignores parity
    setCfg(1'b1, 1'b0, 1'b1, 1'b0);
    sendRx(8'h03, 1'b1, 1'b1, 1'b1);
    check("R11", "no parity flag", {31'h0, parityErr}, 32'h0);
    check("R11", "mp bit one", {31'h0, lastNinth}, 32'h1);
    sendRx(8'h02, 1'b1, 1'b0, 1'b1);
    check("R11", "mp bit zero", {31'h0, lastNinth}, 32'h0);
    check("R11", "mp data", {24'h0, lastData}, 32'h02);

    // framing error
    setCfg(1'b0, 1'b0, 1'b0, 1'b0);
    c0 = rxCount;
    sendRx(8'h5A, 1'b0, 1'b0, 1'b0);
    check("R8", "char delivered", rxCount, c0 + 1);
    check("R8", "frame flag", {31'h0, frameErr}, 32'h1);
    check("R8", "no break", {31'h0, breakErr}, 32'h0);
    waitTicks(20);
    #1 check("R8", "frame flag sticky", {31'h0, frameErr}, 32'h1);
    pulseStatusRead();
    check("R8", "frame flag cleared", {31'h0, frameErr}, 32'h0);

    // break: long low line
    c0 = rxCount;
    rxLine = 1'b0;
    waitTicks(16 * 14);
    #1 rxLine = 1'b1;
    waitTicks(20);
    #1;
    check("R10", "single char on break", rxCount, c0 + 1);
    check("R10", "break data", {24'h0, lastData}, 32'h0);
    check("R10", "break and frame flags", {30'h0, breakErr, frameErr}, 32'h3);
    pulseStatusRead();
    check("R10", "flags cleared", {30'h0, breakErr, frameErr}, 32'h0);
    c0 = rxCount;
    sendRx(8'hC3, 1'b0, 1'b0, 1'b1);
    check("R10", "rearmed after break", rxCount, c0 + 1);
    check("R10", "rearmed data", {24'h0, lastData}, 32'hC3);

    // false start
    c0 = rxCount;
    rxLine = 1'b0;
    waitTicks(3);
    #1 rxLine = 1'b1;
    waitTicks(40);
    #1 check("R7", "glitch rejected", rxCount, c0);

    // receiver disabled
    @(negedge clk) rxEnable = 1'b0;
    c0 = rxCount;
    sendRx(8'h3C, 1'b0, 1'b0, 1'b1);
    check("R6", "no char when disabled", rxCount, c0);
    check("R6", "data held", {24'h0, rxData}, 32'hC3);
    @(negedge clk) rxEnable = 1'b1;
    waitTicks(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule